// File: doc/BRIEF.md
# Module Power-State Sequencer

This block drives a clock enable and a reset line for each of a parameterised set of peripheral modules. Software reaches it through a small register bus. Each module has two registers: a control register holding the state software wants next, and a status register showing the state the module is in now. Changing the control register has no immediate effect. The change is applied only when software writes a start command, after which it polls a busy flag until the sequencer is idle again.

When the start command is accepted, the sequencer records which modules have a requested state that differs from their current one. It also takes a copy of every requested state. It then visits the recorded modules one at a time, in ascending index order. For each one it changes the clock enable first, changes the reset line a fixed number of cycles later, and updates the status register at that same edge. Busy falls at the edge that finishes the last module. All modules sit in one always-on domain.

Top module: `modgate_seq`

## Requirements
- R1: After reset, every module is disabled: `mod_clk_en` is all zeros, `mod_rst` is all ones, every status reads 0, every control reads 0, and busy reads 0.
- R2: The 2-bit state codes are 0 = disabled (clock enable 0, reset 1), 1 = held in synchronous reset (clock enable 1, reset 1) and 3 = running (clock enable 1, reset 0). While idle, each module's outputs match its status code.
- R3: Register map (address, with the field in bits [1:0] or bit 0):
  - 0x00 is the command register. Bit 0 is start, and it reads as 0.
  - 0x01 is the busy flag in bit 0.
  - 0x10+i is the control register of module i, with its next state in bits [1:0].
  - 0x20+i is the status register of module i, with its current state in bits [1:0].
  - Unused addresses read 0.
  - Read data appears on `bus_rdata` one clock after the edge that samples `bus_rd`, and is 0 otherwise.
- R4: A write of 1 to command bit 0 while idle sets busy at that edge. The modules whose control differs from their status become pending at the same edge.
- R5: A module whose requested state equals its status is not touched by a run: its outputs and its status stay unchanged.
- R6: Pending modules are handled one at a time in ascending index order, each taking STEP_CYC cycles. The clock enable changes at the first edge of the module's slot. The reset line and the status change together at the last edge of the slot.
- R7: Busy clears at the edge that finishes the last pending module. A start with nothing pending holds busy for exactly one cycle.
- R8: A write to the command register while busy is ignored.
- R9: A control write of the reserved code 2 is stored as 0, and status never holds 2.
- R10: Control writes made while busy are stored and read back, but the current run uses the requested states copied when it started.
- R11: Writes to status registers and to the busy address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe, sampled at the rising edge |
| bus_rdata | output | DATA_W | Registered read data |
| mod_clk_en | output | NUM_MOD | Clock enable, one bit per module |
| mod_rst | output | NUM_MOD | Active-high reset, one bit per module |

## Verification
Suppose a start is accepted at edge E0 and the j-th pending module is counted from 0. That module's clock enable is due at E0+1+STEP_CYC*j, and its reset and status are due at E0+STEP_CYC*(j+1). Busy drops at E0+STEP_CYC*P, where P is the number of pending modules, or at E0+1 when P is 0. Read data is due one edge after the read strobe is sampled. The bench drives inputs on falling edges and updates a behavioural model at each rising edge. At the falling edge that follows, it compares the outputs with the model. Its directed checks sample at exactly the falling edges that follow the edges listed above.

// File: rtl/modgate_pkg.sv
package modgate_pkg;

    typedef enum logic [1:0] {
        MG_OFF     = 2'd0,
        MG_SYNCRST = 2'd1,
        MG_RSVD    = 2'd2,
        MG_ON      = 2'd3
    } mg_state_e;

    localparam int MG_CMD_ADDR   = 'h00;
    localparam int MG_BUSY_ADDR  = 'h01;
    localparam int MG_CTRL_BASE  = 'h10;
    localparam int MG_STAT_BASE  = 'h20;

    // The reserved code is folded onto the disabled state.
    function automatic logic [1:0] mg_sanitize(input logic [1:0] v);
        return (v == 2'(MG_RSVD)) ? 2'(MG_OFF) : v;
    endfunction

endpackage

// File: rtl/mg_decode.sv
module mg_decode
    import modgate_pkg::*;
(
    input  logic [1:0] state,
    output logic       clk_en,
    output logic       rst_out
);
    always_comb begin
        clk_en  = (state != 2'(MG_OFF));
        rst_out = (state != 2'(MG_ON));
    end
endmodule

// File: rtl/mg_pick.sv
module mg_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/mg_rdmux.sv
module mg_rdmux #(
    parameter int N         = 8,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int BUSY_ADDR = 1,
    parameter int CTRL_BASE = 16,
    parameter int STAT_BASE = 32
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               busy,
    input  logic [N-1:0][1:0]  nxt,
    input  logic [N-1:0][1:0]  cur,
    output logic [DATA_W-1:0]  data
);
    always_comb begin
        data = '0;
        if (int'(addr) == BUSY_ADDR) data = DATA_W'(busy);
        for (int i = 0; i < N; i++) begin
            if (int'(addr) == CTRL_BASE + i) data = DATA_W'(nxt[i]);
            if (int'(addr) == STAT_BASE + i) data = DATA_W'(cur[i]);
        end
    end
endmodule

// File: rtl/modgate_seq.sv
module modgate_seq
    import modgate_pkg::*;
#(
    parameter int NUM_MOD   = 8,
    parameter int STEP_CYC  = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int CMD_ADDR  = MG_CMD_ADDR,
    parameter int BUSY_ADDR = MG_BUSY_ADDR,
    parameter int CTRL_BASE = MG_CTRL_BASE,
    parameter int STAT_BASE = MG_STAT_BASE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_rd,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NUM_MOD-1:0] mod_clk_en,
    output logic [NUM_MOD-1:0] mod_rst
);
    localparam int IDX_W = (NUM_MOD > 1) ? $clog2(NUM_MOD) : 1;
    localparam int CNT_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam int LAST  = STEP_CYC - 1;

    typedef struct packed {
        logic                     busy;
        logic [CNT_W-1:0]         cnt;
        logic [NUM_MOD-1:0]       pend;
        logic [NUM_MOD-1:0][1:0]  nxt;
        logic [NUM_MOD-1:0][1:0]  tgt;
        logic [NUM_MOD-1:0][1:0]  cur;
        logic [NUM_MOD-1:0]       clk_en;
        logic [NUM_MOD-1:0]       rst;
        logic [DATA_W-1:0]        rdata;
    } seq_t;

    localparam seq_t SEQ_RST = '{busy: 1'b0, cnt: '0, pend: '0, nxt: '0,
                                 tgt: '0, cur: '0, clk_en: '0, rst: '1,
                                 rdata: '0};

    seq_t q, d;

    logic [NUM_MOD-1:0] tgt_clk, tgt_rst;
    logic [IDX_W-1:0]   act_idx;
    logic               act_any;
    logic [NUM_MOD-1:0] act_mask;
    logic [DATA_W-1:0]  rd_val;
    logic               go_wr;
    logic               unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:2];

    // Per-module decode of the snapshot target into output levels
    for (genvar g = 0; g < NUM_MOD; g++) begin : g_dec
        mg_decode u_dec (
            .state   (q.tgt[g]),
            .clk_en  (tgt_clk[g]),
            .rst_out (tgt_rst[g])
        );
    end

    mg_pick #(.N(NUM_MOD), .IDX_W(IDX_W)) u_pick (
        .req (q.pend),
        .idx (act_idx),
        .any (act_any)
    );

    mg_rdmux #(
        .N(NUM_MOD), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .BUSY_ADDR(BUSY_ADDR), .CTRL_BASE(CTRL_BASE), .STAT_BASE(STAT_BASE)
    ) u_rdmux (
        .addr (bus_addr),
        .busy (q.busy),
        .nxt  (q.nxt),
        .cur  (q.cur),
        .data (rd_val)
    );

    assign act_mask = {{(NUM_MOD-1){1'b0}}, 1'b1} << act_idx;
    assign go_wr    = bus_wr && (int'(bus_addr) == CMD_ADDR) && bus_wdata[0];

    always_comb begin
        d       = q;
        d.rdata = bus_rd ? rd_val : '0;

        // Control writes are always stored, folded if reserved
        for (int i = 0; i < NUM_MOD; i++) begin
            if (bus_wr && int'(bus_addr) == CTRL_BASE + i)
                d.nxt[i] = mg_sanitize(bus_wdata[1:0]);
        end

        if (!q.busy) begin
            if (go_wr) begin
                d.busy = 1'b1;
                d.cnt  = '0;
                d.tgt  = q.nxt;
                for (int i = 0; i < NUM_MOD; i++)
                    d.pend[i] = (q.nxt[i] != q.cur[i]);
            end
        end else if (!act_any) begin
            d.busy = 1'b0;
        end else begin
            if (q.cnt == '0)
                d.clk_en[act_idx] = tgt_clk[act_idx];
            if (q.cnt == CNT_W'(LAST)) begin
                d.rst[act_idx] = tgt_rst[act_idx];
                d.cur[act_idx] = q.tgt[act_idx];
                d.pend         = q.pend & ~act_mask;
                d.cnt          = '0;
                if ((q.pend & ~act_mask) == '0) d.busy = 1'b0;
            end else begin
                d.cnt = q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RST;
        else        q <= d;
    end

    assign bus_rdata  = q.rdata;
    assign mod_clk_en = q.clk_en;
    assign mod_rst    = q.rst;

    // Assertions

    // R7: nothing is pending once idle
    a_r7_idle_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |-> (q.pend == '0));

    // R6: clock enables move only at the first edge of a slot
    a_r6_clk_at_slot_start: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mod_clk_en) |-> $past(q.busy && q.cnt == '0));

    // R6: reset lines move only at the last edge of a slot
    a_r6_rst_at_slot_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mod_rst) |-> $past(q.busy && q.cnt == CNT_W'(LAST)));

    // R6: at most one module changes per edge
    a_r6_one_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mod_clk_en ^ $past(mod_clk_en)));

    // R8: no module becomes pending while a run is in progress
    a_r8_no_new_pend: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |=> ((q.pend & ~$past(q.pend)) == '0));

    for (genvar g = 0; g < NUM_MOD; g++) begin : g_chk
        // R9: the reserved code never appears in stored state
        a_r9_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
            (q.cur[g] != 2'(MG_RSVD)) && (q.nxt[g] != 2'(MG_RSVD)));

        // R2: when idle, the outputs agree with the status code
        a_r2_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
            !q.busy |-> (mod_clk_en[g] == (q.cur[g] != 2'(MG_OFF))) &&
                        (mod_rst[g] == (q.cur[g] != 2'(MG_ON))));
    end

endmodule

// File: tb/modgate_seq_tb_top.sv
`timescale 1ns/1ps
module modgate_seq_tb_top;
    localparam int N    = 8;
    localparam int STEP = 4;
    localparam int A_CMD = 'h00, A_BUSY = 'h01, A_CTRL = 'h10, A_STAT = 'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [N-1:0] mod_clk_en, mod_rst;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    modgate_seq #(.NUM_MOD(N), .STEP_CYC(STEP)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .mod_clk_en(mod_clk_en), .mod_rst(mod_rst)
    );

    // Behavioural reference model
    int          m_next[N];
    int          m_cur[N];
    int          m_tgt[N];
    bit [N-1:0]  m_clk = '0;
    bit [N-1:0]  m_rst = '1;
    bit          m_busy = 1'b0;
    int          m_q[$];
    int          m_ph = 0;
    logic [31:0] m_rdata = '0;

    function automatic logic [31:0] m_read(int a);
        if (a == A_BUSY) return 32'(m_busy);
        if (a >= A_CTRL && a < A_CTRL + N) return 32'(m_next[a - A_CTRL]);
        if (a >= A_STAT && a < A_STAT + N) return 32'(m_cur[a - A_STAT]);
        return '0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_next[i] = 0; m_cur[i] = 0; m_tgt[i] = 0;
            end
            m_clk = '0; m_rst = '1; m_busy = 0; m_q.delete(); m_ph = 0;
            m_rdata = '0;
        end else begin
            logic [31:0] rv;
            rv = bus_rd ? m_read(int'(bus_addr)) : '0;
            if (m_busy) begin
                if (m_q.size() == 0) m_busy = 0;
                else begin
                    int mi;
                    mi = m_q[0];
                    m_ph++;
                    if (m_ph == 1) m_clk[mi] = (m_tgt[mi] != 0);
                    if (m_ph == STEP) begin
                        m_rst[mi] = (m_tgt[mi] != 3);
                        m_cur[mi] = m_tgt[mi];
                        void'(m_q.pop_front());
                        m_ph = 0;
                        if (m_q.size() == 0) m_busy = 0;
                    end
                end
            end else if (bus_wr && int'(bus_addr) == A_CMD && bus_wdata[0]) begin
                m_busy = 1; m_ph = 0;
                for (int i = 0; i < N; i++) begin
                    m_tgt[i] = m_next[i];
                    if (m_next[i] != m_cur[i]) m_q.push_back(i);
                end
            end
            if (bus_wr && int'(bus_addr) >= A_CTRL && int'(bus_addr) < A_CTRL + N)
                m_next[int'(bus_addr) - A_CTRL] = (bus_wdata[1:0] == 2'd2) ? 0 : int'(bus_wdata[1:0]);
            m_rdata = rv;
        end
    end

    // Cycle-by-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (mod_clk_en !== m_clk) begin
                fails++;
                $display("FAIL R6 clk_en actual=%h expected=%h t=%0t", mod_clk_en, m_clk, $time);
            end
            checks++;
            if (mod_rst !== m_rst) begin
                fails++;
                $display("FAIL R6 rst actual=%h expected=%h t=%0t", mod_rst, m_rst, $time);
            end
            checks++;
            if (bus_rdata !== m_rdata) begin
                fails++;
                $display("FAIL R3 rdata actual=%h expected=%h t=%0t", bus_rdata, m_rdata, $time);
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Bus tasks: called at a falling edge, return at a falling edge
    task automatic wr(int a, logic [31:0] v);
        bus_addr = 8'(a); bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] v);
        bus_addr = 8'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        int n = 0;
        do begin
            rd(A_BUSY, v);
            n++;
        end while (v[0] && n < 500);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        logic [N-1:0] ck_before, rs_before;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 clk_en", 32'(mod_clk_en), 32'h00);
        chk("R1 rst", 32'(mod_rst), 32'hFF);
        rd(A_BUSY, v); chk("R1 busy", v, 0);
        rd(A_STAT + 3, v); chk("R1 status", v, 0);
        rd(A_CTRL + 6, v); chk("R1 control", v, 0);

        // R3 map and unused addresses
        rd('h05, v); chk("R3 unused 05", v, 0);
        rd('h30, v); chk("R3 unused 30", v, 0);
        rd(A_CMD, v); chk("R3 cmd reads 0", v, 0);
        wr(A_CTRL + 1, 1); rd(A_CTRL + 1, v); chk("R3 control readback", v, 1);

        // R9 reserved code folded
        wr(A_CTRL + 3, 2); rd(A_CTRL + 3, v); chk("R9 reserved stored as 0", v, 0);

        // R11 status and busy writes ignored
        wr(A_STAT + 0, 3); rd(A_STAT + 0, v); chk("R11 status write ignored", v, 0);
        wr(A_BUSY, 1); rd(A_BUSY, v); chk("R11 busy write ignored", v, 0);
        chk("R11 outputs untouched", 32'(mod_clk_en), 0);

        // R4 run with three pending modules; R8 and R10 during busy
        wr(A_CTRL + 1, 0);
        wr(A_CTRL + 0, 3); wr(A_CTRL + 2, 1); wr(A_CTRL + 5, 3);
        wr(A_CMD, 1);
        rd(A_BUSY, v); chk("R4 busy set", v, 1);
        wr(A_CTRL + 2, 0);
        wr(A_CTRL + 1, 3);
        wr(A_CMD, 1);
        wait_idle();
        rd(A_STAT + 0, v); chk("R4 status0", v, 3);
        rd(A_STAT + 2, v); chk("R10 snapshot status2", v, 1);
        rd(A_CTRL + 2, v); chk("R10 control2 stored", v, 0);
        rd(A_STAT + 5, v); chk("R4 status5", v, 3);
        rd(A_STAT + 1, v); chk("R8 go while busy ignored", v, 0);
        chk("R2 clk_en levels", 32'(mod_clk_en), 32'h25);
        chk("R2 rst levels", 32'(mod_rst), 32'hDE);

        // R7 start with nothing pending
        wr(A_CTRL + 1, 0); wr(A_CTRL + 2, 1);
        wr(A_CMD, 1);
        rd(A_BUSY, v); chk("R7 empty run busy one cycle", v, 1);
        rd(A_BUSY, v); chk("R7 empty run busy cleared", v, 0);
        chk("R5 empty run clk_en", 32'(mod_clk_en), 32'h25);

        // R6 slot timing on one module; R5 others untouched
        wr(A_CTRL + 4, 3);
        ck_before = mod_clk_en; rs_before = mod_rst;
        wr(A_CMD, 1);                       // sampled at E0
        @(negedge clk);                     // after E1
        chk("R6 clk on at slot start", 32'(mod_clk_en[4]), 1);
        chk("R6 rst held at slot start", 32'(mod_rst[4]), 1);
        @(negedge clk); @(negedge clk);     // after E3
        chk("R6 rst held before slot end", 32'(mod_rst[4]), 1);
        @(negedge clk);                     // after E4
        chk("R6 rst released at slot end", 32'(mod_rst[4]), 0);
        chk("R5 others clk_en", 32'(mod_clk_en & ~8'h10), 32'(ck_before));
        chk("R5 others rst", 32'(mod_rst | 8'h10), 32'(rs_before));
        rd(A_BUSY, v); chk("R7 busy cleared with last module", v, 0);

        // Everything running, then one disabled, then all in sync reset
        for (int i = 0; i < N; i++) wr(A_CTRL + i, 3);
        wr(A_CMD, 1); wait_idle();
        chk("R2 all running clk_en", 32'(mod_clk_en), 32'hFF);
        chk("R2 all running rst", 32'(mod_rst), 32'h00);
        wr(A_CTRL + 0, 0); wr(A_CMD, 1); wait_idle();
        chk("R2 disabled clk_en", 32'(mod_clk_en), 32'hFE);
        chk("R2 disabled rst", 32'(mod_rst), 32'h01);
        for (int i = 0; i < N; i++) wr(A_CTRL + i, 1);
        wr(A_CMD, 1); wait_idle();
        chk("R2 sync reset clk_en", 32'(mod_clk_en), 32'hFF);
        chk("R2 sync reset rst", 32'(mod_rst), 32'hFF);
        rd(A_STAT + 7, v); chk("R2 status7 sync reset", v, 1);

        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule